// File: doc/BRIEF.md
# Fetch Command Queue with Completion Fence

This block carries commands from the execution side of a core to its fetch side. Commands are held in a small first-in first-out store. Each command has a 3-bit opcode, a 3-bit sub-opcode, a program-counter field and an opaque payload. The fetch side takes commands through a valid/ready port. For every command other than a prediction confirmation, the fetch side reports completion with a one-cycle `done_i` pulse. The queue has no clear input. Only reset empties it, because every command that is accepted must be carried out.

The block drives a single fence output. Fence is high only when three things are true: initialisation has finished, the store is empty, and no command is still being processed. The execution side watches this line before it issues further work. Prediction confirmations take a fast path. When one arrives at an empty queue, it is offered to the fetch side in the same cycle, it never needs a completion pulse, and it never lowers the fence. Redirect and state-reset commands also produce a one-cycle flush pulse toward the queue that runs from fetch to execute.

Opcodes: 0 state reset, 1 redirect, 2 prediction confirmation, 3 instruction-cache fence, 4 translation fill, 5 translation fence. Redirect sub-opcodes: 0 mispredict, 1 trap, 2 interrupt, 3 trap return, 4 context switch.

Top module: `fetch_cmd_queue`

## Requirements
- R1: While reset is held and after it is released, `enq_ready_o` is 1 and `deq_valid_o`, `fence_o` and `fq_flush_o` are 0.
- R2: Commands leave in the order they were accepted, with opcode, sub-opcode, PC and payload unchanged.
- R3: A prediction confirmation (opcode 2) that arrives while the store is empty is offered on the dequeue port in the same cycle.
- R4: While `deq_valid_o` is 1 and `deq_ready_i` is 0, the next cycle still shows the same command.
- R5: A non-confirmation command at the head is not offered while an earlier non-confirmation command is still being processed. A confirmation at the head is offered regardless.
- R6: `fq_flush_o` pulses in the cycle after a state reset (opcode 0) or a redirect (opcode 1, any sub-opcode) is dequeued, and at no other time.
- R7: Fence is 0 while a command is being processed. It rises in the second cycle after the `done_i` that ends processing.
- R8: Fence stays 0 from reset until a state-reset command has completed. Completion of any other command does not raise it.
- R9: A command written into the store forces fence to 0 in the next cycle.
- R10: `done_i` while no command is being processed has no effect.
- R11: With DEPTH commands stored, `enq_ready_o` is 0.
- R12: Dequeuing a prediction confirmation neither sets processing nor lowers the fence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enq_valid_i | input | 1 | Command offered by the execution side |
| enq_ready_o | output | 1 | Store can accept a command |
| enq_opcode_i | input | 3 | Command opcode |
| enq_subop_i | input | 3 | Command sub-opcode |
| enq_pc_i | input | PC_W | Command PC |
| enq_payload_i | input | PAY_W | Opaque command payload |
| deq_valid_o | output | 1 | Command offered to the fetch side |
| deq_ready_i | input | 1 | Fetch side takes the command |
| deq_opcode_o | output | 3 | Offered opcode |
| deq_subop_o | output | 3 | Offered sub-opcode |
| deq_pc_o | output | PC_W | Offered PC |
| deq_payload_o | output | PAY_W | Offered payload |
| done_i | input | 1 | Fetch side finished the current command |
| fq_flush_o | output | 1 | Flush pulse toward the fetch-to-execute queue |
| fence_o | output | 1 | All commands absorbed and processed |

## Verification
Each test drives one of four input patterns, and each pattern separates a different kind of fault. The first pattern sends single commands into an idle queue with the consumer ready. This shows whether the flush pulse and the processing flag follow the opcode, and whether fence comes back at exactly the second cycle after completion. The second pattern stalls the consumer while a mixed backlog of confirmations and ordinary commands builds up. This exposes faults in ordering, in holding data under backpressure, in the full condition, and in the rule that confirmations may pass while an earlier command is still being processed. The third and fourth patterns cover the edge cases: confirmations arriving at an empty queue with the consumer ready or stalled, which tests the same-cycle fast path, and completion pulses sent when nothing is processing or before any state reset, which tests fence initialisation.

// File: rtl/fcq_pkg.sv
package fcq_pkg;

  localparam int unsigned OP_W  = 3;
  localparam int unsigned SUB_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_STATE_RESET = 3'd0,
    OP_REDIRECT    = 3'd1,
    OP_PRED_OK     = 3'd2,
    OP_IC_FENCE    = 3'd3,
    OP_TLB_FILL    = 3'd4,
    OP_TLB_FENCE   = 3'd5
  } cmd_op_e;

  typedef enum logic [SUB_W-1:0] {
    SUB_MISPREDICT = 3'd0,
    SUB_TRAP       = 3'd1,
    SUB_INTERRUPT  = 3'd2,
    SUB_TRAP_RET   = 3'd3,
    SUB_CTX_SWITCH = 3'd4
  } redir_sub_e;

endpackage

// File: rtl/fcq_decode.sv
module fcq_decode
  import fcq_pkg::*;
(
  input  logic [OP_W-1:0] opcode_i,
  output logic            is_pred_ok_o,
  output logic            is_flush_o,
  output logic            is_reset_o
);

  always_comb begin
    is_pred_ok_o = 1'b0;
    is_flush_o   = 1'b0;
    is_reset_o   = 1'b0;
    case (cmd_op_e'(opcode_i))
      OP_STATE_RESET: begin
        is_flush_o = 1'b1;
        is_reset_o = 1'b1;
      end
      OP_REDIRECT:    is_flush_o   = 1'b1;
      OP_PRED_OK:     is_pred_ok_o = 1'b1;
      default:        ;
    endcase
  end

endmodule

// File: rtl/fcq_store.sv
module fcq_store #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o
);

  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [AW-1:0]    LAST_PTR = AW'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [W-1:0]     mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, wr_ptr_d;
  logic [AW-1:0]    rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ptr_en;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (push_i) begin
      wr_ptr_d = (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + 1'b1;
    end
    if (pop_i) begin
      rd_ptr_d = (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1;
    end
    case ({push_i, pop_i})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  assign ptr_en = push_i | pop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (ptr_en) begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      mem_q[wr_ptr_q] <= data_i;
    end
  end

  assign head_o  = mem_q[rd_ptr_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == FULL_CNT);

endmodule

// File: rtl/fcq_tracker.sv
module fcq_tracker (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic start_reset_i,
  input  logic done_i,
  input  logic store_empty_i,
  input  logic push_i,
  input  logic flush_req_i,
  output logic busy_o,
  output logic fence_o,
  output logic flush_o
);

  logic busy_q, busy_d;
  logic busy_rst_q, busy_rst_d;
  logic init_q, init_d;
  logic fence_q, fence_d;
  logic flush_q, flush_d;
  logic busy_en;
  logic finish;

  assign finish  = done_i & busy_q;
  assign busy_en = start_i | finish;

  always_comb begin
    busy_d     = busy_q;
    busy_rst_d = busy_rst_q;
    init_d     = init_q;
    if (finish) begin
      busy_d     = 1'b0;
      busy_rst_d = 1'b0;
      if (busy_rst_q) begin
        init_d = 1'b1;
      end
    end
    if (start_i) begin
      busy_d     = 1'b1;
      busy_rst_d = start_reset_i;
    end
    fence_d = init_q & store_empty_i & ~busy_q & ~push_i;
    flush_d = flush_req_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      busy_rst_q <= 1'b0;
    end else if (busy_en) begin
      busy_q     <= busy_d;
      busy_rst_q <= busy_rst_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= 1'b0;
    end else if (finish) begin
      init_q <= init_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fence_q <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      fence_q <= fence_d;
      flush_q <= flush_d;
    end
  end

  assign busy_o  = busy_q;
  assign fence_o = fence_q;
  assign flush_o = flush_q;

endmodule

// File: rtl/fetch_cmd_queue.sv
module fetch_cmd_queue
  import fcq_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned PC_W  = 39,
  parameter int unsigned PAY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enq_valid_i,
  output logic             enq_ready_o,
  input  logic [OP_W-1:0]  enq_opcode_i,
  input  logic [SUB_W-1:0] enq_subop_i,
  input  logic [PC_W-1:0]  enq_pc_i,
  input  logic [PAY_W-1:0] enq_payload_i,
  output logic             deq_valid_o,
  input  logic             deq_ready_i,
  output logic [OP_W-1:0]  deq_opcode_o,
  output logic [SUB_W-1:0] deq_subop_o,
  output logic [PC_W-1:0]  deq_pc_o,
  output logic [PAY_W-1:0] deq_payload_o,
  input  logic             done_i,
  output logic             fq_flush_o,
  output logic             fence_o
);

  localparam int unsigned ENTRY_W = OP_W + SUB_W + PC_W + PAY_W;

  logic [ENTRY_W-1:0] enq_entry, head_entry, deq_entry;
  logic store_empty, store_full;
  logic push, pop, bypass, deq_fire;
  logic busy;
  logic enq_pred_ok, enq_flush_unused, enq_reset_unused;
  logic deq_pred_ok, deq_flush, deq_reset;
  logic head_pred_ok, head_flush_unused, head_reset_unused;

  assign enq_entry = {enq_opcode_i, enq_subop_i, enq_pc_i, enq_payload_i};

  fcq_decode u_dec_enq (
    .opcode_i     (enq_opcode_i),
    .is_pred_ok_o (enq_pred_ok),
    .is_flush_o   (enq_flush_unused),
    .is_reset_o   (enq_reset_unused)
  );

  fcq_decode u_dec_head (
    .opcode_i     (head_entry[ENTRY_W-1 -: OP_W]),
    .is_pred_ok_o (head_pred_ok),
    .is_flush_o   (head_flush_unused),
    .is_reset_o   (head_reset_unused)
  );

  fcq_decode u_dec_deq (
    .opcode_i     (deq_entry[ENTRY_W-1 -: OP_W]),
    .is_pred_ok_o (deq_pred_ok),
    .is_flush_o   (deq_flush),
    .is_reset_o   (deq_reset)
  );

  assign bypass      = store_empty & enq_valid_i & enq_pred_ok;
  assign deq_entry   = bypass ? enq_entry : head_entry;
  assign deq_valid_o = bypass | (~store_empty & (head_pred_ok | ~busy));
  assign deq_fire    = deq_valid_o & deq_ready_i;
  assign enq_ready_o = ~store_full;
  assign push        = enq_valid_i & ~store_full & ~(bypass & deq_ready_i);
  assign pop         = deq_fire & ~bypass;

  fcq_store #(
    .DEPTH (DEPTH),
    .W     (ENTRY_W)
  ) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .data_i  (enq_entry),
    .pop_i   (pop),
    .head_o  (head_entry),
    .empty_o (store_empty),
    .full_o  (store_full)
  );

  fcq_tracker u_track (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (deq_fire & ~deq_pred_ok),
    .start_reset_i (deq_reset),
    .done_i        (done_i),
    .store_empty_i (store_empty),
    .push_i        (push),
    .flush_req_i   (deq_fire & deq_flush),
    .busy_o        (busy),
    .fence_o       (fence_o),
    .flush_o       (fq_flush_o)
  );

  assign deq_opcode_o  = deq_entry[ENTRY_W-1 -: OP_W];
  assign deq_subop_o   = deq_entry[PC_W+PAY_W +: SUB_W];
  assign deq_pc_o      = deq_entry[PAY_W +: PC_W];
  assign deq_payload_o = deq_entry[PAY_W-1:0];

endmodule

// File: rtl/fcq_checker.sv
module fcq_checker
  import fcq_pkg::*;
#(
  parameter int unsigned PC_W = 39
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             deq_valid_o,
  input logic             deq_ready_i,
  input logic [OP_W-1:0]  deq_opcode_o,
  input logic [PC_W-1:0]  deq_pc_o,
  input logic             fq_flush_o,
  input logic             fence_o
);

  logic fire_flushing;
  logic fire_tracked;

  assign fire_flushing = deq_valid_o && deq_ready_i &&
                         (deq_opcode_o == OP_STATE_RESET || deq_opcode_o == OP_REDIRECT);
  assign fire_tracked  = deq_valid_o && deq_ready_i && (deq_opcode_o != OP_PRED_OK);

  a_r6_flush_after_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_flushing |=> fq_flush_o);

  a_r6_flush_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fq_flush_o |-> $past(fire_flushing));

  a_r4_hold_under_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deq_valid_o && !deq_ready_i) |=>
      (deq_valid_o && $stable(deq_opcode_o) && $stable(deq_pc_o)));

  a_r7_fence_drops_on_work: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_tracked |=> !fence_o);

  a_r12_fence_only_confirm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fence_o && deq_valid_o) |-> (deq_opcode_o == OP_PRED_OK));

endmodule

bind fetch_cmd_queue fcq_checker #(.PC_W(PC_W)) u_fcq_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .deq_valid_o  (deq_valid_o),
  .deq_ready_i  (deq_ready_i),
  .deq_opcode_o (deq_opcode_o),
  .deq_pc_o     (deq_pc_o),
  .fq_flush_o   (fq_flush_o),
  .fence_o      (fence_o)
);

// File: tb/test_fetch_cmd_queue.sv
module test_fetch_cmd_queue;

  localparam int unsigned DEPTH = 4;
  localparam int unsigned PC_W  = 39;
  localparam int unsigned PAY_W = 16;
  localparam int unsigned IW    = 3 + 3 + PC_W + PAY_W;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             enq_valid_i = 1'b0;
  logic             enq_ready_o;
  logic [2:0]       enq_opcode_i = '0;
  logic [2:0]       enq_subop_i = '0;
  logic [PC_W-1:0]  enq_pc_i = '0;
  logic [PAY_W-1:0] enq_payload_i = '0;
  logic             deq_valid_o;
  logic             deq_ready_i = 1'b0;
  logic [2:0]       deq_opcode_o;
  logic [2:0]       deq_subop_o;
  logic [PC_W-1:0]  deq_pc_o;
  logic [PAY_W-1:0] deq_payload_o;
  logic             done_i = 1'b0;
  logic             fq_flush_o;
  logic             fence_o;

  int n_checks = 0;
  int n_errors = 0;
  logic [IW-1:0] exp_q[$];
  logic flush_exp = 1'b0;

  always #5 clk_i = ~clk_i;

  fetch_cmd_queue #(.DEPTH(DEPTH), .PC_W(PC_W), .PAY_W(PAY_W)) i_fetch_cmd_queue (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .enq_valid_i(enq_valid_i), .enq_ready_o(enq_ready_o),
    .enq_opcode_i(enq_opcode_i), .enq_subop_i(enq_subop_i),
    .enq_pc_i(enq_pc_i), .enq_payload_i(enq_payload_i),
    .deq_valid_o(deq_valid_o), .deq_ready_i(deq_ready_i),
    .deq_opcode_o(deq_opcode_o), .deq_subop_o(deq_subop_o),
    .deq_pc_o(deq_pc_o), .deq_payload_o(deq_payload_o),
    .done_i(done_i), .fq_flush_o(fq_flush_o), .fence_o(fence_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Drive a command for one cycle; called right after a falling edge.
  task automatic drive(input logic [2:0] op, input logic [2:0] sub, input logic [PC_W-1:0] pc,
                       input logic [PAY_W-1:0] pay);
    enq_valid_i   = 1'b1;
    enq_opcode_i  = op;
    enq_subop_i   = sub;
    enq_pc_i      = pc;
    enq_payload_i = pay;
    exp_q.push_back({op, sub, pc, pay});
  endtask

  task automatic release_enq();
    enq_valid_i = 1'b0;
  endtask

  task automatic send(input logic [2:0] op, input logic [2:0] sub, input logic [PC_W-1:0] pc,
                      input logic [PAY_W-1:0] pay);
    drive(op, sub, pc, pay);
    @(negedge clk_i);
    release_enq();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic pulse_done();
    done_i = 1'b1;
    @(negedge clk_i);
    done_i = 1'b0;
  endtask

  // Scoreboard monitor: samples one ns before each rising edge.
  always begin
    @(negedge clk_i);
    #4;
    if (rst_ni) begin
      chk(fq_flush_o == flush_exp, "R6 flush pulse", 64'(fq_flush_o), 64'(flush_exp));
      flush_exp = 1'b0;
      if (deq_valid_o && deq_ready_i) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected dequeue", 64'(deq_pc_o), 64'd0);
        end else begin
          logic [IW-1:0] e;
          e = exp_q.pop_front();
          chk(e[IW-1 -: 3] == deq_opcode_o, "R2 opcode order", 64'(deq_opcode_o), 64'(e[IW-1 -: 3]));
          chk(e[PC_W+PAY_W +: 3] == deq_subop_o, "R2 subop", 64'(deq_subop_o), 64'(e[PC_W+PAY_W +: 3]));
          chk(e[PAY_W +: PC_W] == deq_pc_o, "R2 pc", 64'(deq_pc_o), 64'(e[PAY_W +: PC_W]));
          chk(e[PAY_W-1:0] == deq_payload_o, "R2 payload", 64'(deq_payload_o), 64'(e[PAY_W-1:0]));
          flush_exp = (e[IW-1 -: 3] == 3'd0) || (e[IW-1 -: 3] == 3'd1);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    n_errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    idle(2);
    #1;
    chk(enq_ready_o == 1'b1, "R1 ready in reset", 64'(enq_ready_o), 64'd1);
    chk(deq_valid_o == 1'b0, "R1 valid in reset", 64'(deq_valid_o), 64'd0);
    chk(fence_o == 1'b0, "R1 fence in reset", 64'(fence_o), 64'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle(1);
    #1;
    chk(fence_o == 1'b0, "R1 fence after reset", 64'(fence_o), 64'd0);
    chk(fq_flush_o == 1'b0, "R1 flush after reset", 64'(fq_flush_o), 64'd0);
    @(negedge clk_i);
    deq_ready_i = 1'b1;

    // R8: completing a non-reset command does not initialise the fence
    send(3'd3, 3'd0, 39'h40, 16'h0003);
    idle(2);
    pulse_done();
    idle(3);
    #1;
    chk(fence_o == 1'b0, "R8 fence before state reset", 64'(fence_o), 64'd0);
    @(negedge clk_i);

    // R6/R7: state reset flushes, fence waits for done, then lags by one
    send(3'd0, 3'd0, 39'h100, 16'hA000);
    idle(4);
    #1;
    chk(fence_o == 1'b0, "R7 fence while processing", 64'(fence_o), 64'd0);
    @(negedge clk_i);
    pulse_done();
    #4;
    chk(fence_o == 1'b0, "R7 fence one cycle after done", 64'(fence_o), 64'd0);
    @(negedge clk_i);
    #4;
    chk(fence_o == 1'b1, "R7 fence two cycles after done", 64'(fence_o), 64'd1);
    @(negedge clk_i);

    // R3/R12: confirmation into empty queue appears at once, fence stays up
    drive(3'd2, 3'd0, 39'h104, 16'h0B01);
    #1;
    chk(deq_valid_o == 1'b1, "R3 same-cycle valid", 64'(deq_valid_o), 64'd1);
    chk(deq_pc_o == 39'h104, "R3 same-cycle pc", 64'(deq_pc_o), 64'h104);
    @(negedge clk_i);
    release_enq();
    idle(2);
    #1;
    chk(fence_o == 1'b1, "R12 fence after confirmation", 64'(fence_o), 64'd1);

    // R10: stray done while idle changes nothing
    @(negedge clk_i);
    pulse_done();
    idle(2);
    #1;
    chk(fence_o == 1'b1, "R10 fence after stray done", 64'(fence_o), 64'd1);
    chk(deq_valid_o == 1'b0, "R10 nothing offered", 64'(deq_valid_o), 64'd0);

    // R9: stored command drops fence next cycle
    @(negedge clk_i);
    drive(3'd4, 3'd0, 39'h2000, 16'h0F11);
    @(negedge clk_i);
    release_enq();
    #4;
    chk(fence_o == 1'b0, "R9 fence after write", 64'(fence_o), 64'd0);
    @(negedge clk_i);
    idle(1);
    pulse_done();
    idle(1);
    #4;
    chk(fence_o == 1'b1, "R7 fence back after fill", 64'(fence_o), 64'd1);
    @(negedge clk_i);

    // R4/R5: backlog with stalled consumer, confirmations pass a busy command
    deq_ready_i = 1'b0;
    send(3'd5, 3'd0, 39'h3000, 16'h0005);
    send(3'd2, 3'd0, 39'h3004, 16'h00A1);
    send(3'd2, 3'd0, 39'h3008, 16'h00A2);
    #1;
    chk(deq_valid_o && deq_opcode_o == 3'd5, "R4 head shown", 64'(deq_opcode_o), 64'd5);
    @(negedge clk_i);
    #1;
    chk(deq_valid_o && deq_pc_o == 39'h3000, "R4 head held", 64'(deq_pc_o), 64'h3000);
    deq_ready_i = 1'b1;
    idle(4);
    #1;
    chk(deq_valid_o == 1'b0, "R5 confirmations drained while busy", 64'(deq_valid_o), 64'd0);
    @(negedge clk_i);
    send(3'd3, 3'd0, 39'h3010, 16'h0033);
    idle(2);
    #1;
    chk(deq_valid_o == 1'b0, "R5 second command blocked", 64'(deq_valid_o), 64'd0);
    @(negedge clk_i);
    pulse_done();
    #1;
    chk(deq_valid_o == 1'b1, "R5 second command offered after done", 64'(deq_valid_o), 64'd1);
    @(negedge clk_i);
    pulse_done();

    // R11: fill the store with the consumer stalled
    deq_ready_i = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      send(3'd2, 3'd0, 39'h4000 + 39'(k * 4), 16'(k));
    end
    #1;
    chk(enq_ready_o == 1'b0, "R11 ready low when full", 64'(enq_ready_o), 64'd0);
    deq_ready_i = 1'b1;
    idle(DEPTH + 1);
    #1;
    chk(enq_ready_o == 1'b1, "R11 ready after drain", 64'(enq_ready_o), 64'd1);
    @(negedge clk_i);

    // R3/R4: fast-path confirmation with stalled consumer is held
    deq_ready_i = 1'b0;
    drive(3'd2, 3'd0, 39'h5000, 16'h0C0C);
    #1;
    chk(deq_valid_o == 1'b1, "R3 stalled fast path valid", 64'(deq_valid_o), 64'd1);
    @(negedge clk_i);
    release_enq();
    #1;
    chk(deq_valid_o && deq_pc_o == 39'h5000, "R4 fast path held", 64'(deq_pc_o), 64'h5000);
    deq_ready_i = 1'b1;
    idle(2);

    // R6: redirect (context switch) flushes, translation fence does not
    send(3'd1, 3'd4, 39'h6000, 16'h0601);
    idle(2);
    pulse_done();
    send(3'd5, 3'd0, 39'h6100, 16'h0602);
    idle(2);
    pulse_done();
    send(3'd1, 3'd0, 39'h6200, 16'h0603);
    idle(2);
    pulse_done();
    idle(3);

    chk(exp_q.size() == 0, "R2 all commands delivered", 64'(exp_q.size()), 64'd0);
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule